// File: doc/BRIEF.md
# Sense-Reversing Hardware Barrier

This block lets a fixed group of participants, sized by the `TOTAL` parameter, meet at a common point before any of them continues. Each participant owns one `arrive` input and one `released` output. A participant that is free to run signals arrival with a one-cycle pulse and then waits, with `released` low, until every other participant has arrived too. At that moment all `released` outputs go high together.

The block can be reused with no gap between episodes. It keeps a private sense bit for each participant and one shared sense bit. Arrival flips the private bit, so the participant waits. The last arrival of an episode flips the shared bit, so every private bit differs from it again. The shared state is never cleared. Each episode only inverts the condition that counts as release. A participant that leaves early and re-arrives therefore waits on the new value of the shared bit. It can never hide the release from a slower participant that has not yet looked at its output.

Top module: `sense_barrier`

## Requirements
- R1: After reset, and whenever reset is applied in the middle of an episode, every `released` output is 1 and the arrival count is zero.
- R2: An `arrive` pulse from a participant whose `released` is 1, when that pulse does not complete the episode, makes that participant's `released` 0 from the next clock edge.
- R3: An `arrive` pulse from a participant whose `released` is 0 is ignored: it is not counted and that output stays 0.
- R4: When the number of accepted arrivals in the episode reaches `TOTAL`, all `released` outputs become 1 on the same clock edge and the count returns to zero.
- R5: Several participants that arrive in the same cycle are all counted in that cycle. If they are all the remaining participants, the episode completes on that edge.
- R6: A participant that is released may arrive again in the very next cycle. That arrival belongs to the new episode and waits for the new episode's other arrivals, so back-to-back reuse never deadlocks.
- R7: A participant's `released` output falls only in the cycle after that participant's own `arrive` was 1.
- R8: `released[i]` is the exclusive-or of participant i's private sense bit and the shared sense bit. It is combinational from those two registers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| arrive | input | TOTAL | One-cycle arrival pulse per participant, bit i for participant i |
| released | output | TOTAL | 1 when participant i may run; 0 while it waits at the barrier |

## Verification
A wrong arrival count shows at the ports within the episode that is running. A stale or inflated count releases the group one arrival early. An undercount leaves everyone waiting after the last arrival. Either mismatch appears on the first edge that should or should not complete the episode. A corrupted private or shared sense bit changes a `released` output on the very next edge. The bench therefore compares all outputs after every stimulus cycle: mid-episode reset, ignored repeat pulses, all-at-once arrival and immediate re-entry.

// File: rtl/barrier_pkg.sv
package barrier_pkg;
  // Reset values chosen so that every participant starts free to run.
  localparam logic PRIV_SENSE_RST   = 1'b1;
  localparam logic SHARED_SENSE_RST = 1'b0;
endpackage

// File: rtl/barrier_local_sense.sv
module barrier_local_sense #(
  parameter int TOTAL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] arrive,
  input  logic             shared_sense,
  output logic [TOTAL-1:0] accept,
  output logic [TOTAL-1:0] released
);
  import barrier_pkg::*;

  logic [TOTAL-1:0] priv_q;

  for (genvar g = 0; g < TOTAL; g++) begin : g_part
    // Only a participant that is currently free may join the episode.
    assign released[g] = priv_q[g] ^ shared_sense;
    assign accept[g]   = arrive[g] & released[g];

    always_ff @(posedge clk) begin
      if (rst) begin
        priv_q[g] <= PRIV_SENSE_RST;
      end else if (accept[g]) begin
        priv_q[g] <= ~priv_q[g];
      end
    end
  end
endmodule

// File: rtl/barrier_tally.sv
module barrier_tally #(
  parameter int TOTAL = 4,
  parameter int CW    = $clog2(TOTAL + 1)
) (
  input  logic [TOTAL-1:0] accept,
  output logic [CW-1:0]    n_accept
);
  always_comb begin
    n_accept = '0;
    for (int i = 0; i < TOTAL; i++) begin
      n_accept = n_accept + CW'(accept[i]);
    end
  end
endmodule

// File: rtl/barrier_episode.sv
module barrier_episode #(
  parameter int TOTAL = 4,
  parameter int CW    = $clog2(TOTAL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] n_accept,
  output logic [CW-1:0] count_q,
  output logic          shared_sense
);
  import barrier_pkg::*;

  localparam int SW = CW + 1;

  logic [SW-1:0] sum;
  logic          complete;

  assign sum      = {1'b0, count_q} + {1'b0, n_accept};
  assign complete = (n_accept != '0) && (sum == SW'(TOTAL));

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q      <= '0;
      shared_sense <= SHARED_SENSE_RST;
    end else if (complete) begin
      // Arrivers now hold the same sense as the old shared bit; inverting the
      // shared bit makes every participant differ from it again.
      count_q      <= '0;
      shared_sense <= ~shared_sense;
    end else begin
      count_q <= sum[CW-1:0];
    end
  end
endmodule

// File: rtl/sense_barrier.sv
module sense_barrier #(
  parameter int TOTAL = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TOTAL-1:0] arrive,
  output logic [TOTAL-1:0] released
);
  localparam int CW = $clog2(TOTAL + 1);

  logic [TOTAL-1:0] accept;
  logic [CW-1:0]    n_accept;
  logic [CW-1:0]    count_q;
  logic             shared_sense;

  barrier_local_sense #(.TOTAL(TOTAL)) i_local (
    .clk          (clk),
    .rst          (rst),
    .arrive       (arrive),
    .shared_sense (shared_sense),
    .accept       (accept),
    .released     (released)
  );

  barrier_tally #(.TOTAL(TOTAL), .CW(CW)) i_tally (
    .accept   (accept),
    .n_accept (n_accept)
  );

  barrier_episode #(.TOTAL(TOTAL), .CW(CW)) i_episode (
    .clk          (clk),
    .rst          (rst),
    .n_accept     (n_accept),
    .count_q      (count_q),
    .shared_sense (shared_sense)
  );
endmodule

// File: rtl/barrier_checker.sv
module barrier_checker #(
  parameter int TOTAL = 4,
  parameter int CW    = $clog2(TOTAL + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic [TOTAL-1:0] arrive,
  input logic [TOTAL-1:0] released,
  input logic [CW-1:0]    count
);
  // R1: first cycle out of reset, everyone is free and nothing counted
  a_r1_reset_free: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (&released) && (count == '0));

  // R3: count stays below the group size, so waiters were never counted
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    count < CW'(TOTAL));

  for (genvar g = 0; g < TOTAL; g++) begin : g_chk
    // R7: a participant only starts waiting after its own arrival
    a_r7_fall_needs_arrive: assert property (@(posedge clk) disable iff (rst)
      $fell(released[g]) |-> $past(arrive[g]));

    // R4: leaving the barrier happens for the whole group at once
    a_r4_release_all: assert property (@(posedge clk) disable iff (rst)
      $rose(released[g]) |-> (&released));

    // R3: a waiter that pulses arrive cannot release itself alone
    a_r3_waiter_held: assert property (@(posedge clk) disable iff (rst)
      (!released[g] && arrive[g]) |=> (!released[g] || (&released)));
  end
endmodule

bind sense_barrier barrier_checker #(.TOTAL(TOTAL), .CW(CW)) i_barrier_checker (
  .clk      (clk),
  .rst      (rst),
  .arrive   (arrive),
  .released (released),
  .count    (count_q)
);

// File: tb/test_sense_barrier.sv
module test_sense_barrier;
  localparam int CLK_PERIOD = 10;
  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] arrive = '0;
  logic [N-1:0] released;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [N-1:0] exp_q[$];
  string        tag_q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  sense_barrier #(.TOTAL(N)) i_sense_barrier (
    .clk      (clk),
    .rst      (rst),
    .arrive   (arrive),
    .released (released)
  );

  task automatic check(input logic [N-1:0] exp, input string tag);
    total++;
    if (released !== exp) begin
      bad++;
      $display("FAIL %s released actual=%b expected=%b", tag, released, exp);
    end
  endtask

  // Driver: apply one cycle of arrivals and queue the outputs expected after the edge.
  task automatic step(input logic [N-1:0] v, input logic [N-1:0] exp, input string tag);
    @(negedge clk);
    arrive = v;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  // Monitor: compare just after every edge that consumed a queued stimulus.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() != 0) begin
        logic [N-1:0] e;
        string        t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(e, t);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(4'b1111, "R1 after reset");
    step(4'b0000, 4'b1111, "R1 idle keeps all free");
    step(4'b0001, 4'b1110, "R2 first arrival waits");
    step(4'b0001, 4'b1110, "R3 repeat pulse ignored");
    step(4'b0010, 4'b1100, "R2 second arrival");
    step(4'b0100, 4'b1000, "R2 third arrival");
    step(4'b0011, 4'b1000, "R3 waiters pulse, not counted");
    step(4'b1000, 4'b1111, "R4 last arrival releases all");
    step(4'b0001, 4'b1110, "R6 immediate re-entry waits");
    step(4'b0001, 4'b1110, "R3 re-entered waiter ignored");
    step(4'b1110, 4'b1111, "R5 three together complete");
    step(4'b1111, 4'b1111, "R5 all four in one cycle");
    step(4'b0011, 4'b1100, "R5 two together");
    step(4'b1111, 4'b1111, "R3 R5 only free pair counted");
    step(4'b0101, 4'b1010, "R2 partial episode");
    @(negedge clk);
    arrive = '0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(4'b1111, "R1 mid-episode reset");
    step(4'b0011, 4'b1100, "R1 count cleared by reset");
    step(4'b1100, 4'b1111, "R4 completes after reset");
    step(4'b0000, 4'b1111, "R8 outputs hold when idle");
    @(negedge clk);
    arrive = '0;
    @(posedge clk);
    #2;
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule